// File: doc/BRIEF.md
# Instruction Prefix Fusion Decoder

This block sits in the decode stage of a core. It watches the instruction stream for one reserved 16-bit compressed encoding that acts as a prefix. The block takes in a prefix parcel without sending anything downstream. It keeps the eleven payload bits of that prefix and merges them with the next instruction, which may be 16-bit or 32-bit, to form a single vector-style macro-op. The merged operation carries 7-bit register numbers, so it can reach 128 registers. It also carries a vector length, an element width and a predicate selector that the block passes on without decoding it.

An instruction without a prefix passes through in the same cycle with neutral vector attributes. The input and the output use valid/ready handshakes. The output path is combinational, so a fused operation leaves in the same cycle as the instruction that completes it. A prefix followed by a second prefix is reported as an illegal instruction. A flush drops any prefix the block is holding.

Top module: `pfx_fuse_dec`

## Requirements
- R1: A 16-bit parcel (`in_is32`=0) with bits 15:13 = 3'b100 and bits 1:0 = 2'b00 is a prefix. When no prefix is held, the block accepts it (`in_ready`=1) and produces no output. A 32-bit parcel is never a prefix, whatever its low half holds.
- R2: A non-prefix parcel with no prefix held appears on the output in the same cycle. `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, `out_insn`/`out_is32` equal the input, and `out_fused`=0.
- R3: The prefix payload sits in prefix bits 12:2. For a 32-bit instruction after a prefix, the output fields are: rd = {p[12:11], i[11:7]}, rs1 = {p[10:9], i[19:15]}, rs2 = {p[10:9], i[24:20]}, rs3 = {p[10:9], i[31:27]}. `out_fused` is 1.
- R4: For a fused instruction, `out_vl` = p[8:7] + 1, which gives 1 to 4.
- R5: For a fused instruction, `out_ew` = 8 << p[6:5], which gives 8, 16, 32 or 64. `out_pred` = p[4:2].
- R6: An instruction without a prefix gets `out_vl`=1, `out_ew`=64 and `out_pred`=0. Its register extension bits are zero, so a 32-bit rd is {2'b00, i[11:7]}.
- R7: A 16-bit instruction with bits 1:0 = 2'b00 uses 3-bit fields. These give rd = {dx, 2'b01, i[4:2]}, rs1 = {sx, 2'b01, i[9:7]} and rs2 = {sx, 2'b01, i[4:2]}. Any other 16-bit instruction gives rd = {dx, i[11:7]}, rs1 = {sx, i[11:7]} and rs2 = {sx, i[6:2]}. In both cases rs3 = 0. Here dx and sx are the destination and source extensions, or zero when no prefix is held.
- R8: A held prefix stays held, with its payload unchanged, while the following instruction waits on `out_ready`=0. It is applied when the handshake completes and is cleared after that.
- R9: While `flush` is high, `in_ready` and `out_valid` are 0. After the flush any held prefix is gone.
- R10: A prefix that arrives while a prefix is already held is output with `out_illegal`=1 and `out_fused`=0, and default attributes. On that handshake the second prefix replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop any held prefix |
| in_valid | input | 1 | Input parcel valid |
| in_ready | output | 1 | Input parcel accepted |
| in_bits | input | 32 | Instruction bits; upper half ignored when 16-bit |
| in_is32 | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| out_valid | output | 1 | Macro-op valid |
| out_ready | input | 1 | Downstream accepts macro-op |
| out_insn | output | 32 | Original instruction bits |
| out_is32 | output | 1 | Instruction length flag |
| out_rd | output | 7 | Widened destination register |
| out_rs1 | output | 7 | Widened source register 1 |
| out_rs2 | output | 7 | Widened source register 2 |
| out_rs3 | output | 7 | Widened source register 3 |
| out_vl | output | 3 | Vector length, 1 to 4 |
| out_ew | output | 7 | Element width in bits |
| out_pred | output | 3 | Predicate selector, uninterpreted |
| out_fused | output | 1 | A prefix was applied |
| out_illegal | output | 1 | Prefix followed by prefix |

## Verification
The assertions check several properties on every cycle:
- every valid output has a vector length from 1 to 4 and a single power-of-two element width;
- an operation without a prefix carries the neutral attributes;
- no output is both fused and illegal;
- a prefix taken in sets the held state;
- a held prefix keeps its payload through a stall;
- a flush empties the held state.

Other behaviour can only be shown by the bench scenarios, because it depends on exact bit values:
- the exact bit placement of the widened registers for 32-bit, compressed-quadrant-zero and other compressed forms;
- the payload-to-VL and payload-to-width mapping;
- the double-prefix replacement, which shows up in the attributes of the next instruction.

// File: rtl/pfx_fuse_dec.sv
module pfx_fuse_dec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_bits,
  input  logic        in_is32,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_insn,
  output logic        out_is32,
  output logic [6:0]  out_rd,
  output logic [6:0]  out_rs1,
  output logic [6:0]  out_rs2,
  output logic [6:0]  out_rs3,
  output logic [2:0]  out_vl,
  output logic [6:0]  out_ew,
  output logic [2:0]  out_pred,
  output logic        out_fused,
  output logic        out_illegal
);

  logic        held;
  logic [10:0] pay;

  wire pshape = ~in_is32 & (in_bits[15:13] == 3'b100) & (in_bits[1:0] == 2'b00);
  wire is_pfx = in_valid & pshape;
  wire absorb = is_pfx & ~held;
  wire fuse   = held & ~pshape;

  assign in_ready    = ~flush & (absorb | out_ready);
  assign out_valid   = in_valid & ~flush & ~absorb;
  assign out_insn    = in_bits;
  assign out_is32    = in_is32;
  assign out_fused   = fuse;
  assign out_illegal = held & pshape;

  wire [1:0] dx  = fuse ? pay[10:9] : 2'b00;
  wire [1:0] sx  = fuse ? pay[8:7]  : 2'b00;
  wire [1:0] vlc = fuse ? pay[6:5]  : 2'b00;
  wire [1:0] ewc = fuse ? pay[4:3]  : 2'b11;

  assign out_vl   = {1'b0, vlc} + 3'd1;
  assign out_ew   = 7'd8 << ewc;
  assign out_pred = fuse ? pay[2:0] : 3'b000;

  always_comb begin
    if (in_is32) begin
      out_rd  = {dx, in_bits[11:7]};
      out_rs1 = {sx, in_bits[19:15]};
      out_rs2 = {sx, in_bits[24:20]};
      out_rs3 = {sx, in_bits[31:27]};
    end else if (in_bits[1:0] == 2'b00) begin
      out_rd  = {dx, 2'b01, in_bits[4:2]};
      out_rs1 = {sx, 2'b01, in_bits[9:7]};
      out_rs2 = {sx, 2'b01, in_bits[4:2]};
      out_rs3 = 7'd0;
    end else begin
      out_rd  = {dx, in_bits[11:7]};
      out_rs1 = {sx, in_bits[11:7]};
      out_rs2 = {sx, in_bits[6:2]};
      out_rs3 = 7'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      pay  <= '0;
    end else if (flush) begin
      held <= 1'b0;
    end else if (is_pfx && in_ready) begin
      held <= 1'b1;
      pay  <= in_bits[12:2];
    end else if (out_valid && out_ready) begin
      held <= 1'b0;
    end
  end

  AST_PFX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pfx && !held && !flush) |=> held); // R1
  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vl >= 3'd1 && out_vl <= 3'd4)); // R4
  AST_EW_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_ew) == 1 && out_ew >= 7'd8)); // R5
  AST_PLAIN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fused) |-> (out_vl == 3'd1 && out_ew == 7'd64 && out_pred == 3'd0)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !flush && !(in_valid && in_ready)) |=> (held && $stable(pay))); // R8
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !held); // R9
  AST_FUSE_XOR_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_fused && out_illegal)); // R10

endmodule

// File: tb/sim_pfx_fuse_dec.sv
module sim_pfx_fuse_dec;
  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, in_is32 = 0, out_ready = 1;
  logic [31:0] in_bits = '0;
  logic in_ready, out_valid, out_is32, out_fused, out_illegal;
  logic [31:0] out_insn;
  logic [6:0] out_rd, out_rs1, out_rs2, out_rs3, out_ew;
  logic [2:0] out_vl, out_pred;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pfx_fuse_dec u0 (.clk, .rst_n, .flush, .in_valid, .in_ready, .in_bits, .in_is32,
    .out_valid, .out_ready, .out_insn, .out_is32, .out_rd, .out_rs1, .out_rs2, .out_rs3,
    .out_vl, .out_ew, .out_pred, .out_fused, .out_illegal);

  typedef struct packed {
    logic        usep;
    logic [15:0] pfx;
    logic [31:0] insn;
    logic        is32;
    logic [6:0]  rd, rs1, rs2, rs3;
    logic [2:0]  vl;
    logic [6:0]  ew;
    logic [2:0]  pred;
    logic        fused;
  } vec_t;

  localparam logic [31:0] I32 = {5'd31, 2'b00, 5'd17, 5'd10, 3'b000, 5'd3, 7'h43};
  localparam vec_t TBL [4] = '{
    '{1'b1, 16'h9B14, I32, 1'b1, 7'd99, 7'd42, 7'd49, 7'd63, 3'd3, 7'd8, 3'd5, 1'b1},
    '{1'b0, 16'h0000, I32, 1'b1, 7'd3, 7'd10, 7'd17, 7'd31, 3'd1, 7'd64, 3'd0, 1'b0},
    '{1'b1, 16'h8DE8, 32'h0000_4298, 1'b0, 7'd46, 7'd77, 7'd78, 7'd0, 3'd4, 7'd64, 3'd2, 1'b1},
    '{1'b0, 16'h0000, 32'h0000_94D2, 1'b0, 7'd9, 7'd9, 7'd20, 7'd0, 3'd1, 7'd64, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input [31:0] b, input logic is32);
    @(negedge clk);
    in_valid = 1; in_bits = b; in_is32 = is32;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R2 reset out_valid", out_valid, 0);
    chk("R2 reset in_ready", in_ready, 1);

    foreach (TBL[k]) begin
      if (TBL[k].usep) begin
        drive({16'h0, TBL[k].pfx}, 0);
        chk("R1 prefix no output", out_valid, 0);
        chk("R1 prefix accepted", in_ready, 1);
        @(posedge clk);
      end
      drive(TBL[k].insn, TBL[k].is32);
      chk("R2 valid", out_valid, 1);
      chk("R2 insn", out_insn, TBL[k].insn);
      chk(TBL[k].is32 ? "R3 rd" : "R7 rd", out_rd, TBL[k].rd);
      chk(TBL[k].is32 ? "R3 rs1" : "R7 rs1", out_rs1, TBL[k].rs1);
      chk(TBL[k].is32 ? "R3 rs2" : "R7 rs2", out_rs2, TBL[k].rs2);
      chk(TBL[k].is32 ? "R3 rs3" : "R7 rs3", out_rs3, TBL[k].rs3);
      chk(TBL[k].usep ? "R4 vl" : "R6 vl", out_vl, TBL[k].vl);
      chk(TBL[k].usep ? "R5 ew" : "R6 ew", out_ew, TBL[k].ew);
      chk("R5 pred", out_pred, TBL[k].pred);
      chk("R3 fused", out_fused, TBL[k].fused);
      @(posedge clk);
      idle();
    end

    // R1: a 32-bit parcel whose low half looks like a prefix is passed on as-is
    drive(32'h0000_9B14, 1);
    chk("R1 32-bit not prefix", out_valid, 1);
    chk("R1 32-bit not fused", out_fused, 0);
    @(posedge clk); idle();

    // R8: stall while holding a prefix
    drive(32'h0000_9B14, 0); @(posedge clk);
    @(negedge clk); out_ready = 0; in_bits = I32; in_is32 = 1; #1;
    for (int c = 0; c < 3; c++) begin
      chk("R8 stalled valid", out_valid, 1);
      chk("R8 stalled in_ready", in_ready, 0);
      chk("R8 stalled fused", out_fused, 1);
      @(negedge clk); #1;
    end
    chk("R8 held rd", out_rd, 7'd99);
    out_ready = 1; #1;
    chk("R8 ready in_ready", in_ready, 1);
    @(posedge clk);
    drive(I32, 1);
    chk("R8 cleared after use", out_fused, 0);
    @(posedge clk); idle();

    // R9: flush drops a held prefix
    drive(32'h0000_8DE8, 0); @(posedge clk);
    @(negedge clk); in_valid = 0; flush = 1; #1;
    chk("R9 flush in_ready", in_ready, 0);
    @(negedge clk); flush = 0;
    drive(I32, 1);
    chk("R9 flushed not fused", out_fused, 0);
    chk("R9 flushed vl", out_vl, 1);
    @(posedge clk); idle();

    // R10: prefix followed by prefix
    drive(32'h0000_9B14, 0); @(posedge clk);
    drive(32'h0000_8DE8, 0);
    chk("R10 valid", out_valid, 1);
    chk("R10 illegal", out_illegal, 1);
    chk("R10 not fused", out_fused, 0);
    chk("R10 default vl", out_vl, 1);
    @(posedge clk);
    drive(I32, 1);
    chk("R10 second prefix vl", out_vl, 4);
    chk("R10 second prefix rd", out_rd, {2'b01, 5'd3});
    chk("R10 illegal clear", out_illegal, 0);
    @(posedge clk); idle();

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule